// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block is a square grid of N×N multiply-accumulate cells that forms C = A × B, where A has N rows and K columns and B has K rows and N columns. Each accumulator stays in its own cell for the whole product. On each accepted beat the caller presents one column of A, which is one 8-bit element per row, and one row of B, which is one 8-bit element per column. The elements are given unskewed. Inside the block, the A lane of row r is delayed by r cycles and the B lane of column c by c cycles. A operands then move one cell to the right per cycle and B operands move one cell down per cycle. The k-th elements of a matching pair therefore meet at every cell in the same cycle, and that cell adds their product to its 32-bit running sum.

A product begins with a start beat, which clears the grid. The start beat also captures the length K, the operand signedness and the active tile size. Beats can have gaps between them. A one-cycle done pulse reports the moment the far corner cell has taken its last pair. Rows and columns outside the active tile get zero operands, so smaller tiles need no padding from the caller. Results are read one row at a time through a combinational row-select port.

Top module: `osmm_array`

## Requirements
- R1: After reset, done is low and every row read through rd_data is all zeros.
- R2: With mode=0, each operand is an 8-bit two's-complement value. On the k-th accepted beat, a_vec[8r+7:8r] holds A[r][k] and b_vec[8c+7:8c] holds B[k][c]. After done, element (i,j) of the active tile reads as the sum over k of A[i][k]·B[k][j].
- R3: With mode=1, operands are unsigned values from 0 to 255 and are otherwise treated as in R2.
- R4: done is high for exactly one cycle. That cycle is the (2N-1)-th cycle after the cycle that carries the K-th accepted beat. With contiguous beats this is K+2N-2 cycles after the start beat. A k_len of 0 or 1 means a single beat.
- R5: Inside a product, a cycle with valid low contributes nothing, and the operand data in that cycle is ignored. A product with gaps gives the same result as the same product without gaps, with done delayed by the gap cycles.
- R6: A start beat, meaning start and valid high in the same cycle, clears every accumulator and is itself beat k=0. It captures k_len, mode, act_rows and act_cols, and later changes to these inputs have no effect. A start beat may fall in the done cycle of the previous product, and no earlier value then leaks into the new result.
- R7: When no product is in progress, valid without start changes neither the results nor done.
- R8: Accumulators in rows i ≥ act_rows or columns j ≥ act_cols read zero whatever operand data is driven on those lanes.
- R9: Accumulation wraps modulo 2^32 with no saturation.
- R10: rd_data presents accumulator row rd_row combinationally. Column j appears at bits [32j+31:32j].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | With valid: first beat of a new product, clears the grid |
| valid | input | 1 | Beat strobe for a_vec and b_vec |
| k_len | input | KW | Number of beats K, captured on the start beat |
| mode | input | 1 | 0 = signed operands, 1 = unsigned operands |
| act_rows | input | RSW | Active rows of the tile (0..N) |
| act_cols | input | RSW | Active columns of the tile (0..N) |
| a_vec | input | N*DW | One element per row of A for the current k |
| b_vec | input | N*DW | One element per column of B for the current k |
| rd_row | input | RDW | Accumulator row to present on rd_data |
| done | output | 1 | One-cycle pulse when the product is complete |
| rd_data | output | N*AW | Accumulators of the selected row |

## Verification
Most internal faults show up at the read port as soon as done rises. A skew or forwarding stage of the wrong length pairs A[i][k] with B[k'][j], so only the off-diagonal cells and the far rows and columns come out wrong. A clear that arrives too late leaves the previous product's sum in the next result. A bad mask shows up as non-zero values outside the tile. A miscounted beat or drain stage moves the done pulse by whole cycles, and the check on the pulse's exact cycle catches that. A wrong sign extension appears only with negative or large unsigned operands. A wrong accumulator width appears only after tens of thousands of large unsigned products.

// File: rtl/osmm_pkg.sv
package osmm_pkg;
  typedef enum logic {
    OPM_SIGNED   = 1'b0,
    OPM_UNSIGNED = 1'b1
  } opmode_e;
endpackage

// File: rtl/osmm_skew.sv
// Fixed-depth delay line that staggers one operand lane at the array edge.
module osmm_skew #(
  parameter int W     = 9,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] sr_q [DEPTH];
  logic [W-1:0] sr_n [DEPTH];

  always_comb begin
    sr_n[0] = d;
    for (int s = 1; s < DEPTH; s++) sr_n[s] = sr_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < DEPTH; s++) sr_q[s] <= '0;
    end else begin
      for (int s = 0; s < DEPTH; s++) sr_q[s] <= sr_n[s];
    end
  end

  assign q = sr_q[DEPTH-1];
endmodule

// File: rtl/osmm_cell.sv
// One multiply-accumulate cell; the clear term is folded into the first MAC.
module osmm_cell #(
  parameter int EW = 9,
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic signed [EW-1:0] a,
  input  logic signed [EW-1:0] b,
  output logic        [AW-1:0] acc
);
  localparam int PW = 2 * EW;

  logic signed [PW-1:0] prod;
  logic        [AW-1:0] acc_q;
  logic        [AW-1:0] acc_n;

  always_comb begin
    prod  = a * b;
    acc_n = (clr ? '0 : acc_q) + {{(AW-PW){prod[PW-1]}}, prod};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_n;
  end

  assign acc = acc_q;
endmodule

// File: rtl/osmm_ctrl.sv
// Beat counting, configuration capture and the drain tag pipe that yields done.
module osmm_ctrl
  import osmm_pkg::*;
#(
  parameter int N   = 4,
  parameter int KW  = 17,
  parameter int RSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           valid,
  input  logic [KW-1:0]  k_len,
  input  logic           mode,
  input  logic [RSW-1:0] act_rows,
  input  logic [RSW-1:0] act_cols,
  output logic           accept,
  output logic           clr,
  output opmode_e        mode_eff,
  output logic [RSW-1:0] rows_eff,
  output logic [RSW-1:0] cols_eff,
  output logic           last_beat,
  output logic           busy,
  output logic           done
);
  localparam int DL = 2 * N - 1;

  logic           busy_q, busy_n;
  logic [KW-1:0]  cnt_q, cnt_n;
  logic [KW-1:0]  klen_q;
  opmode_e        mode_q;
  logic [RSW-1:0] rows_q, cols_q;
  logic [DL-1:0]  tag_q, tag_n;
  logic           cnt_en;

  always_comb begin
    clr       = start && valid;
    accept    = valid && (busy_q || start);
    last_beat = clr ? (k_len <= KW'(1))
                    : (busy_q && valid && ((cnt_q + KW'(1)) == klen_q));
    mode_eff  = clr ? opmode_e'(mode) : mode_q;
    rows_eff  = clr ? act_rows : rows_q;
    cols_eff  = clr ? act_cols : cols_q;
    cnt_en    = accept;
    cnt_n     = clr ? KW'(1) : cnt_q + KW'(1);
    busy_n    = busy_q;
    if (accept) busy_n = !last_beat;
    tag_n     = {tag_q[DL-2:0], last_beat};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      tag_q  <= '0;
    end else begin
      busy_q <= busy_n;
      tag_q  <= tag_n;
      if (cnt_en) cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      klen_q <= '0;
      mode_q <= OPM_SIGNED;
      rows_q <= '0;
      cols_q <= '0;
    end else if (clr) begin
      klen_q <= k_len;
      mode_q <= opmode_e'(mode);
      rows_q <= act_rows;
      cols_q <= act_cols;
    end
  end

  assign busy = busy_q;
  assign done = tag_q[DL-1];
endmodule

// File: rtl/osmm_array.sv
// Top: edge masking and skew, forwarding registers, cell grid, row read port.
module osmm_array
  import osmm_pkg::*;
#(
  parameter int N   = 4,
  parameter int DW  = 8,
  parameter int AW  = 32,
  parameter int KW  = 17,
  localparam int RSW = $clog2(N + 1),
  localparam int RDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            valid,
  input  logic [KW-1:0]   k_len,
  input  logic            mode,
  input  logic [RSW-1:0]  act_rows,
  input  logic [RSW-1:0]  act_cols,
  input  logic [N*DW-1:0] a_vec,
  input  logic [N*DW-1:0] b_vec,
  input  logic [RDW-1:0]  rd_row,
  output logic            done,
  output logic [N*AW-1:0] rd_data
);
  localparam int EW = DW + 1;

  logic           accept, clr, last_beat, busy;
  opmode_e        mode_eff;
  logic [RSW-1:0] rows_eff, cols_eff;

  logic [EW-1:0] a_inj [N];
  logic [EW-1:0] b_inj [N];
  logic [EW-1:0] a_skw [N];
  logic [EW-1:0] b_skw [N];
  logic [EW-1:0] a_fwd_q [N][N-1];
  logic [EW-1:0] a_fwd_n [N][N-1];
  logic [EW-1:0] b_fwd_q [N-1][N];
  logic [EW-1:0] b_fwd_n [N-1][N];
  logic [AW-1:0] acc [N][N];

  osmm_ctrl #(.N(N), .KW(KW), .RSW(RSW)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .valid(valid), .k_len(k_len),
    .mode(mode), .act_rows(act_rows), .act_cols(act_cols), .accept(accept),
    .clr(clr), .mode_eff(mode_eff), .rows_eff(rows_eff), .cols_eff(cols_eff),
    .last_beat(last_beat), .busy(busy), .done(done)
  );

  // Edge injection: zero for idle cycles, gaps and lanes outside the tile.
  always_comb begin
    for (int r = 0; r < N; r++) begin
      a_inj[r] = '0;
      b_inj[r] = '0;
      if (accept && (RSW'(r) < rows_eff))
        a_inj[r] = {(mode_eff == OPM_SIGNED) && a_vec[r*DW+DW-1], a_vec[r*DW +: DW]};
      if (accept && (RSW'(r) < cols_eff))
        b_inj[r] = {(mode_eff == OPM_SIGNED) && b_vec[r*DW+DW-1], b_vec[r*DW +: DW]};
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_skew
    if (r == 0) begin : g_direct
      assign a_skw[r] = a_inj[r];
      assign b_skw[r] = b_inj[r];
    end else begin : g_delay
      osmm_skew #(.W(EW), .DEPTH(r)) i_skew_a (
        .clk(clk), .rst_n(rst_n), .d(a_inj[r]), .q(a_skw[r]));
      osmm_skew #(.W(EW), .DEPTH(r)) i_skew_b (
        .clk(clk), .rst_n(rst_n), .d(b_inj[r]), .q(b_skw[r]));
    end
  end

  // One register per hop: A moves right, B moves down.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      a_fwd_n[i][0] = a_skw[i];
      for (int j = 1; j < N - 1; j++) a_fwd_n[i][j] = a_fwd_q[i][j-1];
    end
    for (int j = 0; j < N; j++) begin
      b_fwd_n[0][j] = b_skw[j];
      for (int i = 1; i < N - 1; i++) b_fwd_n[i][j] = b_fwd_q[i-1][j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N - 1; j++) a_fwd_q[i][j] <= '0;
      for (int i = 0; i < N - 1; i++)
        for (int j = 0; j < N; j++) b_fwd_q[i][j] <= '0;
    end else begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N - 1; j++) a_fwd_q[i][j] <= a_fwd_n[i][j];
      for (int i = 0; i < N - 1; i++)
        for (int j = 0; j < N; j++) b_fwd_q[i][j] <= b_fwd_n[i][j];
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      logic [EW-1:0] a_in, b_in;
      if (j == 0) begin : g_a_edge
        assign a_in = a_skw[i];
      end else begin : g_a_hop
        assign a_in = a_fwd_q[i][j-1];
      end
      if (i == 0) begin : g_b_edge
        assign b_in = b_skw[j];
      end else begin : g_b_hop
        assign b_in = b_fwd_q[i-1][j];
      end
      osmm_cell #(.EW(EW), .AW(AW)) i_cell (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .a($signed(a_in)), .b($signed(b_in)), .acc(acc[i][j]));
    end
  end

  always_comb begin
    for (int j = 0; j < N; j++) rd_data[j*AW +: AW] = acc[rd_row][j];
  end
endmodule

// File: rtl/osmm_array_chk.sv
module osmm_array_chk #(
  parameter int N   = 4,
  parameter int AW  = 32,
  parameter int RSW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           done,
  input logic           last_beat,
  input logic           clr,
  input logic           busy,
  input logic [RSW-1:0] rows_eff,
  input logic [AW-1:0]  corner_acc
);
  localparam int CW = $clog2(2 * N + 1);
  localparam logic [CW-1:0] LAT = CW'(2 * N - 1);
  localparam logic [CW-1:0] SAT = CW'(2 * N);

  logic [CW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          since_q <= '0;
    else if (last_beat)                  since_q <= CW'(1);
    else if (since_q != '0 && since_q != SAT) since_q <= since_q + CW'(1);
  end

  // R4: single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: pulse lands 2N-1 cycles after the last accepted beat
  a_r4_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (since_q == LAT));

  // R6: a start beat leaves no stale sum in the far corner
  a_r6_clear_corner: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (corner_acc == '0));

  // R8: last row stays zero while it is outside the active tile
  a_r8_masked_row: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clr && (rows_eff < RSW'(N))) |-> (corner_acc == '0));
endmodule

bind osmm_array osmm_array_chk #(.N(N), .AW(AW), .RSW(RSW)) i_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .last_beat(last_beat), .clr(clr),
  .busy(busy), .rows_eff(rows_eff), .corner_acc(acc[N-1][N-1])
);

// File: tb/test_osmm_array.sv
module test_osmm_array;
  localparam int N   = 4;
  localparam int DW  = 8;
  localparam int AW  = 32;
  localparam int KW  = 17;
  localparam int RSW = 3;
  localparam int RDW = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start, valid, mode;
  logic [KW-1:0]   k_len;
  logic [RSW-1:0]  act_rows, act_cols;
  logic [N*DW-1:0] a_vec, b_vec;
  logic [RDW-1:0]  rd_row;
  logic            done;
  logic [N*AW-1:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit fill_ff = 1'b0;

  logic [7:0]  A_m [N][64];
  logic [7:0]  B_m [N][64];
  logic [31:0] exp_c [N][N];

  always #2 clk = ~clk;

  osmm_array #(.N(N), .DW(DW), .AW(AW), .KW(KW)) i_osmm_array (
    .clk(clk), .rst_n(rst_n), .start(start), .valid(valid), .k_len(k_len),
    .mode(mode), .act_rows(act_rows), .act_cols(act_cols), .a_vec(a_vec),
    .b_vec(b_vec), .rd_row(rd_row), .done(done), .rd_data(rd_data));

  function automatic logic [7:0] elem_a(int r, int k);
    return fill_ff ? 8'hFF : A_m[r][k % 64];
  endfunction

  function automatic logic [7:0] elem_b(int c, int k);
    return fill_ff ? 8'hFF : B_m[c][k % 64];
  endfunction

  function automatic longint ext8(logic [7:0] v, bit md);
    return md ? longint'(v) : longint'($signed(v));
  endfunction

  task automatic fill(int seed, int style);
    logic [7:0] xt [4];
    xt[0] = 8'h80; xt[1] = 8'h7F; xt[2] = 8'hFF; xt[3] = 8'h01;
    for (int r = 0; r < N; r++)
      for (int k = 0; k < 64; k++) begin
        if (style == 0) begin
          A_m[r][k] = 8'((r * 37 + k * 11 + seed * 53 + 7) ^ (k * 5));
          B_m[r][k] = 8'((r * 71 + k * 29 + seed * 13 + 3) ^ (r * 9));
        end else begin
          A_m[r][k] = xt[(r + k + seed) % 4];
          B_m[r][k] = xt[(r * 3 + k + seed) % 4];
        end
      end
  endtask

  task automatic compute_exp(int K, bit md, int rr, int cc);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        longint s = 0;
        if (i < rr && j < cc)
          for (int k = 0; k < K; k++) s += ext8(elem_a(i, k), md) * ext8(elem_b(j, k), md);
        exp_c[i][j] = s[31:0];
      end
  endtask

  task automatic check_rows(string tag);
    for (int r = 0; r < N; r++) begin
      logic [N*AW-1:0] ev;
      for (int j = 0; j < N; j++) ev[j*AW +: AW] = exp_c[r][j];
      rd_row = RDW'(r);
      #1;
      n_chk++;
      if (rd_data !== ev) begin
        n_bad++;
        $display("FAIL %s row %0d: actual %h expected %h", tag, r, rd_data, ev);
      end
    end
  endtask

  // Caller is at a negedge. quick=1 returns at the done-cycle negedge without reading.
  task automatic run(int K, bit md, int rr, int cc, bit gap, bit quick, string tag);
    int first = 0;
    int hits  = 0;
    for (int k = 0; k < K; k++) begin
      start = (k == 0);
      valid = 1'b1;
      if (k == 0) begin
        k_len = KW'(K); mode = md; act_rows = RSW'(rr); act_cols = RSW'(cc);
      end
      for (int r = 0; r < N; r++) begin
        a_vec[r*DW +: DW] = elem_a(r, k);
        b_vec[r*DW +: DW] = elem_b(r, k);
      end
      @(negedge clk);
      if (k == 0) begin
        // Captured values must no longer matter (R6).
        k_len = KW'(K + 5); mode = ~md; act_rows = RSW'(N); act_cols = RSW'(N);
      end
      start = 1'b0;
      if (gap && k < K - 1)
        for (int g = 0; g < k % 3; g++) begin
          valid = 1'b0;
          a_vec = 32'hA5C3_5A3C;
          b_vec = 32'h3C5A_C3A5;
          @(negedge clk);
        end
    end
    valid = 1'b0;
    a_vec = 32'h5A5A_A5A5;
    b_vec = 32'hC3C3_3C3C;
    for (int m = 1; m <= 9; m++) begin
      if (done) begin
        hits++;
        if (first == 0) first = m;
      end
      if (quick && done) break;
      @(negedge clk);
    end
    n_chk++;
    if (first != 2 * N - 1 || hits != 1) begin
      n_bad++;
      $display("FAIL %s done (R4): actual first %0d pulses %0d expected first %0d pulses 1",
               tag, first, hits, 2 * N - 1);
    end
    compute_exp(K, md, rr, cc);
    if (!quick) check_rows(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; valid = 1'b0; mode = 1'b0; k_len = '0;
    act_rows = RSW'(N); act_cols = RSW'(N); a_vec = '0; b_vec = '0; rd_row = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    n_chk++;
    if (done !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 done: actual %b expected 0", done);
    end
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) exp_c[i][j] = '0;
    check_rows("R1");

    fill(1, 0); run(4, 1'b0, 4, 4, 1'b0, 1'b0, "R2");
    fill(2, 0); run(1, 1'b0, 4, 4, 1'b0, 1'b0, "R4");
    fill(3, 0); run(9, 1'b0, 4, 4, 1'b1, 1'b0, "R5");
    fill(4, 1); run(5, 1'b1, 4, 4, 1'b0, 1'b0, "R3");
    fill(5, 1); run(6, 1'b0, 4, 4, 1'b0, 1'b0, "R2");
    fill(6, 0); run(7, 1'b1, 4, 4, 1'b0, 1'b0, "R10");

    // R7: stray beats while idle
    begin
      int seen = 0;
      for (int c = 0; c < 5; c++) begin
        valid = 1'b1; a_vec = 32'h7F7F_7F7F; b_vec = 32'h8181_8181;
        @(negedge clk);
      end
      valid = 1'b0;
      for (int c = 0; c < 10; c++) begin
        if (done) seen++;
        @(negedge clk);
      end
      n_chk++;
      if (seen != 0) begin
        n_bad++;
        $display("FAIL R7 done: actual %0d pulses expected 0", seen);
      end
      check_rows("R7");
    end

    // R6: new product started in the done cycle of the previous one
    fill(7, 0); run(6, 1'b0, 4, 4, 1'b0, 1'b1, "R6");
    fill(8, 0); run(3, 1'b1, 4, 4, 1'b0, 1'b0, "R6");

    // R8: partial tiles with live data on masked lanes
    fill(9, 0);  run(5, 1'b0, 2, 3, 1'b0, 1'b0, "R8");
    fill(10, 1); run(4, 1'b1, 1, 4, 1'b0, 1'b0, "R8");
    fill(11, 0); run(4, 1'b0, 4, 1, 1'b1, 1'b0, "R8");
    fill(12, 0); run(3, 1'b0, 0, 4, 1'b0, 1'b0, "R8");

    // Sweep of tile shapes, both signedness modes
    for (int md = 0; md < 2; md++)
      for (int rr = 1; rr <= N; rr++)
        for (int cc = 1; cc <= N; cc++) begin
          fill(rr * 7 + cc * 3 + md, (rr + cc) % 2);
          run(3 + (rr + cc) % 3, md[0], rr, cc, 1'b0, 1'b0, "R8");
        end

    // R9: unsigned 255*255 summed past 2^32
    fill_ff = 1'b1;
    run(66100, 1'b1, 4, 4, 1'b0, 1'b0, "R9");
    fill_ff = 1'b0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule